// File: doc/BRIEF.md
# Paged Register Open-Drain GPIO Bank

This block is a byte-wide, register-mapped bank of open-drain I/O lines arranged as 8-bit ports (six by default, 48 lines). A host reaches it through a simple synchronous bus with an address, write data, registered read data, a write strobe and a read strobe. Every line has its own output latch. Setting a latch bit turns on a current sink that pulls the pin low. Clearing it releases the pin, and an external pull-up then holds it high, so the same line can be used as an input. A read of a port returns the complement of the pin levels after a two-flop synchronizer.

The upper part of the address map is a three-byte window whose meaning depends on a page selected in a control register. Page 0 leaves the window empty. Pages 1, 2 and 3 forward window accesses to an external edge-detect unit through a register-side interface that carries the page number, the byte index, strobes and data. The same control register holds one write-lock bit per port. A separate status address reads the edge-detect unit's pending-interrupt byte.

Top module: `gpio_paged_bank`

## Requirements
- R1: After reset every port latch is 0, so all pin sink enables are low. The control register at address 7 reads 0x00 and port reads return 0x00 while the pins float high.
- R2: A write to address p (0 to 5) of an unlocked port loads the latch of pins 8p+7..8p, and `pin_oe` shows the new value from the next clock edge. A 1 bit sinks the pin low and a 0 bit releases it.
- R3: A read of address p returns the bitwise complement of pins 8p+7..8p through a two-flop synchronizer. A pin change first shows in a read issued two cycles after the change, and a read issued in the cycle right after a latch write still returns the old level.
- R4: Port addresses 0 to 5 behave identically whichever page is selected.
- R5: Address 7 is the control register. Bits 7:6 select the page (0 to 3) and bit k (k = 0 to 5) locks port k. The register reads back as written.
- R6: While a port's lock bit is 1, writes to that port leave its latch and pins unchanged. Reads of the port still return the pin levels.
- R7: A read of address 6 returns the `irq_pend` input. Writes to address 6 have no effect.
- R8: On pages 1 to 3, an access to addresses 8, 9 or 10 pulses `ext_wr` or `ext_rd` in the same cycle, with `ext_page` equal to the page, `ext_idx` equal to address minus 8 and `ext_wdata` equal to the write data. The read returns `ext_rdata`.
- R9: On page 0 an access to addresses 8 to 10 forwards nothing and reads 0x00. Addresses 11 to 15 read 0x00 on every page.
- R10: `rdata` is loaded only at the clock edge that ends a cycle with `rd` high. It holds its value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| pin_in | input | 48 | Sampled pin levels |
| pin_oe | output | 48 | Per-pin sink enable (drive low when 1) |
| irq_pend | input | 8 | Pending-interrupt status from the edge-detect unit |
| ext_page | output | 2 | Selected page presented to the edge-detect unit |
| ext_idx | output | 2 | Byte index within the paged window |
| ext_wr | output | 1 | Forwarded write strobe for the paged window |
| ext_rd | output | 1 | Forwarded read strobe for the paged window |
| ext_wdata | output | 8 | Forwarded write data |
| ext_rdata | input | 8 | Read data from the edge-detect unit |

## Verification
The assertions assume that `wr` and `rd` are never high together and that `addr` and `wdata` are steady for the whole strobe cycle. The bench drives every bus cycle from one task on the falling edge and raises only one strobe at a time. The assertions also assume that `irq_pend` holds its value across the edge where a status read is captured, and the bench changes it only while the bus is idle. Pin inputs come from a bench model of open-drain wiring, so `pin_in` is a function of `pin_oe` and a bench-controlled external pull-down.

// File: rtl/gpio_paged_bank.sv
module gpio_paged_bank #(
  parameter int PORTS = 6,
  localparam int NPINS = PORTS * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       addr,
  input  logic [7:0]       wdata,
  input  logic             wr,
  input  logic             rd,
  output logic [7:0]       rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_oe,
  input  logic [7:0]       irq_pend,
  output logic [1:0]       ext_page,
  output logic [1:0]       ext_idx,
  output logic             ext_wr,
  output logic             ext_rd,
  output logic [7:0]       ext_wdata,
  input  logic [7:0]       ext_rdata
);

  logic [1:0]       page;
  logic [5:0]       lock;
  logic [NPINS-1:0] latch, sync1, sync2;
  logic [7:0]       rd_mux;

  wire in_win   = (addr[3:2] == 2'b10) && (addr[1:0] != 2'b11);
  wire win_live = in_win && (page != 2'd0);

  assign ext_page  = page;
  assign ext_idx   = addr[1:0];
  assign ext_wdata = wdata;
  assign ext_wr    = wr && win_live;
  assign ext_rd    = rd && win_live;
  assign pin_oe    = latch;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      page <= 2'd0;
      lock <= 6'd0;
    end else if (wr && addr == 4'd7) begin
      page <= wdata[7:6];
      lock <= wdata[5:0];
    end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        latch[p*8 +: 8] <= 8'h00;
      else if (wr && addr == 4'(p) && !lock[p])
        latch[p*8 +: 8] <= wdata;

    a_r2_oe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == 4'(p) && !lock[p]) |=> pin_oe[p*8 +: 8] == $past(wdata));

    a_r6_lock_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == 4'(p) && lock[p]) |=> $stable(pin_oe[p*8 +: 8]));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '1;
      sync2 <= '1;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end

  always_comb begin
    rd_mux = 8'h00;
    for (int p = 0; p < PORTS; p++)
      if (addr == 4'(p)) rd_mux = ~sync2[p*8 +: 8];
    if (addr == 4'd6) rd_mux = irq_pend;
    if (addr == 4'd7) rd_mux = {page, lock};
    if (win_live)     rd_mux = ext_rdata;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  rdata <= 8'h00;
    else if (rd) rdata <= rd_mux;

  a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));

  a_r9_page0_window_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && in_win && page == 2'd0) |=> rdata == 8'h00);

  a_r9_high_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr > 4'd10) |=> rdata == 8'h00);

  a_r7_status_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == 4'd6) |=> rdata == $past(irq_pend));

endmodule

// File: tb/sim_gpio_paged_bank.sv
module sim_gpio_paged_bank;
  localparam int NP = 48;

  logic clk = 0, rst_n = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, irq_pend = 0;
  logic wr = 0, rd = 0;
  logic [7:0] rdata, ext_wdata, ext_rdata;
  logic [NP-1:0] pin_oe, pin_in, ext_low = '0;
  logic [1:0] ext_page, ext_idx;
  logic ext_wr, ext_rd;

  always #5 clk = ~clk;

  assign pin_in = ~(pin_oe | ext_low);

  logic [7:0] ext_mem [4][3];
  initial for (int i = 0; i < 4; i++) for (int j = 0; j < 3; j++) ext_mem[i][j] = 8'h00;
  assign ext_rdata = (ext_idx < 2'd3) ? ext_mem[ext_page][ext_idx] : 8'h00;
  int ext_wr_cnt = 0;
  always @(posedge clk) if (ext_wr) begin
    ext_mem[ext_page][ext_idx] <= ext_wdata;
    ext_wr_cnt <= ext_wr_cnt + 1;
  end

  gpio_paged_bank u0 (.clk, .rst_n, .addr, .wdata, .wr, .rd, .rdata, .pin_in, .pin_oe,
    .irq_pend, .ext_page, .ext_idx, .ext_wr, .ext_rd, .ext_wdata, .ext_rdata);

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= rd;
  always @(negedge clk) if (rd_seen && exp_q.size() > 0)
    check(tag_q.pop_front(), rdata, exp_q.pop_front());

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic bus_rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; rd = 1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd = 0;
  endtask

  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  logic [7:0] held;
  int wcnt;
  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 oe after reset", pin_oe, 0);
    bus_rd(4'd7, 8'h00, "R1 control reset");
    bus_rd(4'd0, 8'h00, "R1 port reset read");

    bus_wr(4'd0, 8'hA5);
    check("R2 port0 sink enables", pin_oe[7:0], 8'hA5);
    idle(3);
    bus_rd(4'd0, 8'hA5, "R3 port0 inverted read");

    ext_low[23:16] = 8'h3C;
    idle(3);
    bus_rd(4'd2, 8'h3C, "R3 external pull-down read");

    bus_wr(4'd1, 8'hFF);
    bus_rd(4'd1, 8'h00, "R3 synchronizer lag old value");
    idle(3);
    bus_rd(4'd1, 8'hFF, "R3 new value after lag");

    bus_wr(4'd7, 8'h42);
    bus_rd(4'd7, 8'h42, "R5 control readback");
    bus_wr(4'd1, 8'h00);
    check("R6 locked port pins", pin_oe[15:8], 8'hFF);
    idle(3);
    bus_rd(4'd1, 8'hFF, "R6 locked port still readable");
    bus_rd(4'd0, 8'hA5, "R4 port0 read on page1");
    bus_wr(4'd0, 8'h0F);
    check("R4 port0 write on page1", pin_oe[7:0], 8'h0F);

    wcnt = ext_wr_cnt;
    bus_wr(4'd8, 8'h11);
    bus_wr(4'd10, 8'h33);
    check("R8 forwarded writes count", ext_wr_cnt, wcnt + 2);
    check("R8 page1 idx0 stored", ext_mem[1][0], 8'h11);
    check("R8 page1 idx2 stored", ext_mem[1][2], 8'h33);
    bus_rd(4'd8, 8'h11, "R8 page1 readback");
    bus_wr(4'd7, 8'h82);
    bus_wr(4'd9, 8'h55);
    check("R8 page2 idx1 stored", ext_mem[2][1], 8'h55);
    bus_rd(4'd9, 8'h55, "R8 page2 readback");
    bus_wr(4'd7, 8'h42);
    bus_rd(4'd9, 8'h00, "R8 page1 idx1 untouched");
    ext_mem[3][0] = 8'hC3;
    bus_wr(4'd7, 8'hC0);
    bus_rd(4'd8, 8'hC3, "R8 page3 read");
    bus_wr(4'd1, 8'h00);
    check("R6 unlock allows write", pin_oe[15:8], 8'h00);

    bus_wr(4'd7, 8'h00);
    wcnt = ext_wr_cnt;
    bus_wr(4'd8, 8'h77);
    check("R9 page0 no forward", ext_wr_cnt, wcnt);
    bus_rd(4'd8, 8'h00, "R9 page0 window reads zero");
    bus_rd(4'd12, 8'h00, "R9 unused address zero");
    bus_wr(4'd7, 8'h40);
    bus_rd(4'd15, 8'h00, "R9 unused address zero page1");
    bus_wr(4'd7, 8'h00);

    irq_pend = 8'h5A;
    bus_rd(4'd6, 8'h5A, "R7 status read");
    bus_wr(4'd6, 8'hFF);
    check("R7 status write leaves pins", pin_oe, {16'h0, 8'h3C & 8'h00, 8'h00, 8'h00, 8'h0F});
    bus_rd(4'd7, 8'h00, "R7 status write leaves control");
    bus_rd(4'd6, 8'h5A, "R7 status unchanged");

    idle(1);
    held = rdata;
    irq_pend = 8'h00;
    idle(4);
    check("R10 rdata holds", rdata, held);

    bus_wr(4'd0, 8'h00);
    check("R2 release pins", pin_oe[7:0], 8'h00);
    idle(3);
    bus_rd(4'd0, 8'h00, "R2 released pins read high");

    idle(3);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule